// File: doc/BRIEF.md
# Issue Packet Dependence Checker

This block looks at a packet of up to six decoded instructions that are candidates for issue in the same cycle. It finds out how many of them, counted from the oldest slot, can leave together with no register dependence between them. Every ordered pair of distinct valid slots is compared. The comparisons cover general-register operands (7-bit specifiers) and predicate operands (6-bit specifiers). They detect read-after-write, write-after-read and write-after-write conflicts.

For each slot the block raises a hold flag and three hazard-type flags when that slot conflicts with an older slot in the same packet. It also produces an issue count, which is the index of the first slot that must wait. Instructions already in flight, renaming and execution are handled elsewhere. By default the outputs are registered, and a parameter selects purely combinational outputs instead.

Top module: `issue_hazard_check`

## Requirements
- R1: A valid slot j whose used source (src_a or src_b) equals the enabled, non-zero general destination of a valid older slot i<j raises raw_flag[j].
- R2: A valid slot j whose enabled, non-zero general destination equals a used source of a valid older slot i<j raises war_flag[j].
- R3: Two valid slots i<j whose enabled, non-zero general destinations are equal raise waw_flag[j].
- R4: Predicates follow the same rules through the same flags. The qualifying predicate of j matching the predicate destination of older i raises raw_flag[j]. The predicate destination of j matching the qualifying predicate of older i raises war_flag[j]. Equal predicate destinations raise waw_flag[j].
- R5: An instruction whose destination equals one of its own sources creates no hazard.
- R6: A write to general register 0 or to predicate 0 never creates a hazard of any type.
- R7: A source takes part only when its use bit is set, a destination only when its write bit is set, and a slot only when its valid bit is set.
- R8: issue_cnt is the index of the lowest slot that is either invalid or holds a hazard, and 6 when there is none. Slot 0 is never flagged.
- R9: With OUT_REG=1 (default), all outputs appear on the clock edge after the inputs. A synchronous active-high reset drives every output to zero.
- R10: hold_flag[j] is set exactly when any of the three type flags of slot j is set. Only the younger slot of a conflicting pair is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | SLOTS | Slot holds an instruction; bit 0 is the oldest |
| src_a | input | SLOTS*GW | First general source of each slot, slot k at bits k*GW |
| src_a_use | input | SLOTS | First source is read |
| src_b | input | SLOTS*GW | Second general source of each slot |
| src_b_use | input | SLOTS | Second source is read |
| dst | input | SLOTS*GW | General destination of each slot |
| dst_we | input | SLOTS | General destination is written |
| qual_pred | input | SLOTS*PW | Qualifying predicate of each slot (always read) |
| pdst | input | SLOTS*PW | Predicate destination of each slot |
| pdst_we | input | SLOTS | Predicate destination is written |
| hold_flag | output | SLOTS | Slot conflicts with an older slot |
| raw_flag | output | SLOTS | Read-after-write conflict on this slot |
| war_flag | output | SLOTS | Write-after-read conflict on this slot |
| waw_flag | output | SLOTS | Write-after-write conflict on this slot |
| issue_cnt | output | $clog2(SLOTS+1) | Number of leading slots that may issue |

## Verification
The bench targets self-overlap, writes to register 0 and predicate 0, cleared use and write bits, and an invalid slot in the middle of the packet. A design that mishandled these would raise false holds and issue too few instructions. It also sends packets with two hazards in different slots, two hazard types in one slot, a hazard in the last slot, and an invalid slot 0. A count that took the last hazard rather than the first, or that ignored an invalid leading slot, would issue dependent instructions together. Predicate-only conflicts are covered separately, so a checker that compares general registers alone would miss them.

// File: rtl/issue_hazard_check.sv
module issue_hazard_check #(
  parameter int SLOTS   = 6,
  parameter int GW      = 7,
  parameter int PW      = 6,
  parameter int OUT_REG = 1,
  localparam int CW     = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLOTS-1:0]    slot_valid,
  input  logic [SLOTS*GW-1:0] src_a,
  input  logic [SLOTS-1:0]    src_a_use,
  input  logic [SLOTS*GW-1:0] src_b,
  input  logic [SLOTS-1:0]    src_b_use,
  input  logic [SLOTS*GW-1:0] dst,
  input  logic [SLOTS-1:0]    dst_we,
  input  logic [SLOTS*PW-1:0] qual_pred,
  input  logic [SLOTS*PW-1:0] pdst,
  input  logic [SLOTS-1:0]    pdst_we,
  output logic [SLOTS-1:0]    hold_flag,
  output logic [SLOTS-1:0]    raw_flag,
  output logic [SLOTS-1:0]    war_flag,
  output logic [SLOTS-1:0]    waw_flag,
  output logic [CW-1:0]       issue_cnt
);

  logic [GW-1:0] sa [SLOTS];
  logic [GW-1:0] sb [SLOTS];
  logic [GW-1:0] dr [SLOTS];
  logic [PW-1:0] qp [SLOTS];
  logic [PW-1:0] pd [SLOTS];
  logic [SLOTS-1:0] gwr, pwr;

  for (genvar k = 0; k < SLOTS; k++) begin : g_unpack
    assign sa[k]  = src_a[k*GW +: GW];
    assign sb[k]  = src_b[k*GW +: GW];
    assign dr[k]  = dst[k*GW +: GW];
    assign qp[k]  = qual_pred[k*PW +: PW];
    assign pd[k]  = pdst[k*PW +: PW];
    assign gwr[k] = dst_we[k] && (dr[k] != '0);
    assign pwr[k] = pdst_we[k] && (pd[k] != '0);
  end

  logic [SLOTS-1:0] raw_c, war_c, waw_c, hold_c;
  logic [CW-1:0]    cnt_c;

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      raw_c[j] = 1'b0;
      war_c[j] = 1'b0;
      waw_c[j] = 1'b0;
      for (int i = 0; i < j; i++) begin
        if (slot_valid[i] && slot_valid[j]) begin
          if ((gwr[i] && ((src_a_use[j] && sa[j] == dr[i]) ||
                          (src_b_use[j] && sb[j] == dr[i]))) ||
              (pwr[i] && qp[j] == pd[i]))
            raw_c[j] = 1'b1;
          if ((gwr[j] && ((src_a_use[i] && sa[i] == dr[j]) ||
                          (src_b_use[i] && sb[i] == dr[j]))) ||
              (pwr[j] && qp[i] == pd[j]))
            war_c[j] = 1'b1;
          if ((gwr[i] && gwr[j] && dr[i] == dr[j]) ||
              (pwr[i] && pwr[j] && pd[i] == pd[j]))
            waw_c[j] = 1'b1;
        end
      end
    end
  end

  assign hold_c = raw_c | war_c | waw_c;

  always_comb begin
    logic found;
    found = 1'b0;
    cnt_c = CW'(SLOTS);
    for (int k = 0; k < SLOTS; k++) begin
      if (!found && (!slot_valid[k] || hold_c[k])) begin
        cnt_c = CW'(k);
        found = 1'b1;
      end
    end
  end

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_flag <= '0;
        raw_flag  <= '0;
        war_flag  <= '0;
        waw_flag  <= '0;
        issue_cnt <= '0;
      end else begin
        hold_flag <= hold_c;
        raw_flag  <= raw_c;
        war_flag  <= war_c;
        waw_flag  <= waw_c;
        issue_cnt <= cnt_c;
      end
    end
  end else begin : g_comb
    assign hold_flag = hold_c;
    assign raw_flag  = raw_c;
    assign war_flag  = war_c;
    assign waw_flag  = waw_c;
    assign issue_cnt = cnt_c;
  end

endmodule

// File: rtl/issue_hazard_check_sva.sv
module issue_hazard_check_sva #(
  parameter int SLOTS   = 6,
  parameter int OUT_REG = 1,
  localparam int CW     = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [SLOTS-1:0] slot_valid,
  input logic [SLOTS-1:0] hold_flag,
  input logic [CW-1:0]    issue_cnt
);

  logic             rst_q = 1'b0;
  logic [SLOTS-1:0] vseen;
  logic [SLOTS-1:0] lowmask;

  always_ff @(posedge clk) rst_q <= rst;

  if (OUT_REG != 0) begin : g_vreg
    logic [SLOTS-1:0] v_q;
    always_ff @(posedge clk) v_q <= rst ? '0 : slot_valid;
    assign vseen = v_q;

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (hold_flag == '0 && issue_cnt == '0));
  end else begin : g_vcomb
    assign vseen = slot_valid;
  end

  always_comb
    for (int k = 0; k < SLOTS; k++) lowmask[k] = (CW'(k) < issue_cnt);

  a_r8_slot0_free: assert property (@(posedge clk) disable iff (rst)
    !hold_flag[0]);

  a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
    issue_cnt <= CW'(SLOTS));

  a_r8_prefix_clean: assert property (@(posedge clk) disable iff (rst)
    ((hold_flag & lowmask) == '0) && ((~vseen & lowmask) == '0));

  a_r8_stop_reason: assert property (@(posedge clk) disable iff (rst)
    (issue_cnt < CW'(SLOTS)) |-> (!vseen[issue_cnt] || hold_flag[issue_cnt]));

  a_r7_flags_on_valid: assert property (@(posedge clk) disable iff (rst)
    (hold_flag & ~vseen) == '0);

endmodule

bind issue_hazard_check issue_hazard_check_sva #(.SLOTS(SLOTS), .OUT_REG(OUT_REG)) u_sva (
  .clk(clk), .rst(rst), .slot_valid(slot_valid),
  .hold_flag(hold_flag), .issue_cnt(issue_cnt)
);

// File: tb/issue_hazard_check_tb_top.sv
module issue_hazard_check_tb_top;
  localparam int S = 6, GW = 7, PW = 6;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [S-1:0] slot_valid = '0, src_a_use = '0, src_b_use = '0, dst_we = '0, pdst_we = '0;
  logic [S*GW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [S*PW-1:0] qual_pred = '0, pdst = '0;
  logic [S-1:0] hold_flag, raw_flag, war_flag, waw_flag;
  logic [2:0] issue_cnt;

  issue_hazard_check dut_i (
    .clk(clk), .rst(rst), .slot_valid(slot_valid),
    .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
    .dst(dst), .dst_we(dst_we), .qual_pred(qual_pred), .pdst(pdst), .pdst_we(pdst_we),
    .hold_flag(hold_flag), .raw_flag(raw_flag), .war_flag(war_flag),
    .waw_flag(waw_flag), .issue_cnt(issue_cnt)
  );

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // staged packet
  logic b_v [S]; logic b_ua [S]; logic b_ub [S]; logic b_wd [S]; logic b_wp [S];
  logic [GW-1:0] b_sa [S]; logic [GW-1:0] b_sb [S]; logic [GW-1:0] b_d [S];
  logic [PW-1:0] b_q [S]; logic [PW-1:0] b_pd [S];

  task automatic base_pkt();
    for (int k = 0; k < S; k++) begin
      b_v[k] = 1; b_ua[k] = 1; b_ub[k] = 1; b_wd[k] = 1; b_wp[k] = 0;
      b_sa[k] = GW'(10 + k); b_sb[k] = GW'(20 + k); b_d[k] = GW'(40 + k);
      b_q[k] = '0; b_pd[k] = '0;
    end
  endtask

  typedef struct {
    logic [S-1:0] raw, war, waw;
    int cnt;
    string tag;
  } exp_t;
  exp_t exp_q [$];

  task automatic apply_pkt();
    for (int k = 0; k < S; k++) begin
      slot_valid[k] = b_v[k]; src_a_use[k] = b_ua[k]; src_b_use[k] = b_ub[k];
      dst_we[k] = b_wd[k]; pdst_we[k] = b_wp[k];
      src_a[k*GW +: GW] = b_sa[k]; src_b[k*GW +: GW] = b_sb[k];
      dst[k*GW +: GW] = b_d[k];
      qual_pred[k*PW +: PW] = b_q[k]; pdst[k*PW +: PW] = b_pd[k];
    end
  endtask

  task automatic send(input logic [S-1:0] raw, input logic [S-1:0] war,
                      input logic [S-1:0] waw, input int cnt, input string tag);
    exp_t e;
    @(negedge clk);
    apply_pkt();
    e.raw = raw; e.war = war; e.waw = waw; e.cnt = cnt; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: registered result visible after the next rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(raw_flag == e.raw, {e.tag, " raw"}, raw_flag, e.raw);
      check(war_flag == e.war, {e.tag, " war"}, war_flag, e.war);
      check(waw_flag == e.waw, {e.tag, " waw"}, waw_flag, e.waw);
      check(hold_flag == (e.raw | e.war | e.waw), {e.tag, " R10 hold"}, hold_flag, e.raw | e.war | e.waw);
      check(int'(issue_cnt) == e.cnt, {e.tag, " R8 cnt"}, issue_cnt, e.cnt);
    end
  end

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset holds outputs at zero even with a hazardous packet driven
    base_pkt(); b_sa[3] = 7'd41; apply_pkt();
    repeat (3) @(negedge clk);
    check(hold_flag == '0 && raw_flag == '0 && war_flag == '0 && waw_flag == '0, "R9 reset flags", hold_flag, 0);
    check(issue_cnt == '0, "R9 reset cnt", issue_cnt, 0);
    rst = 1'b0;

    base_pkt();                                   send(6'h00, 6'h00, 6'h00, 6, "R8 clean packet");
    base_pkt(); b_sa[3] = 7'd41;                  send(6'h08, 6'h00, 6'h00, 3, "R1 raw gpr");
    base_pkt(); b_d[4] = 7'd12;                   send(6'h00, 6'h10, 6'h00, 4, "R2 war gpr");
    base_pkt(); b_d[2] = 7'd40;                   send(6'h00, 6'h00, 6'h04, 2, "R3 waw gpr");
    base_pkt(); b_d[1] = 7'd11;                   send(6'h00, 6'h00, 6'h00, 6, "R5 self overlap");
    base_pkt(); b_d[1] = 0; b_sa[3] = 0; b_d[4] = 0;
                                                  send(6'h00, 6'h00, 6'h00, 6, "R6 gpr zero");
    base_pkt(); b_sa[3] = 7'd41; b_ua[3] = 0;     send(6'h00, 6'h00, 6'h00, 6, "R7 use gate");
    base_pkt(); b_sa[3] = 7'd41; b_wd[1] = 0;     send(6'h00, 6'h00, 6'h00, 6, "R7 write gate");
    base_pkt(); b_v[2] = 0; b_sa[4] = 7'd42;      send(6'h00, 6'h00, 6'h00, 2, "R7 invalid slot");
    base_pkt(); b_pd[1] = 6'd5; b_wp[1] = 1; b_q[2] = 6'd5;
                                                  send(6'h04, 6'h00, 6'h00, 2, "R4 raw pred");
    base_pkt(); b_q[0] = 6'd7; b_pd[3] = 6'd7; b_wp[3] = 1;
                                                  send(6'h00, 6'h08, 6'h00, 3, "R4 war pred");
    base_pkt(); b_pd[1] = 6'd9; b_wp[1] = 1; b_pd[4] = 6'd9; b_wp[4] = 1;
                                                  send(6'h00, 6'h00, 6'h10, 4, "R4 waw pred");
    base_pkt(); b_wp[1] = 1; b_wp[3] = 1;         send(6'h00, 6'h00, 6'h00, 6, "R6 pred zero");
    base_pkt(); b_sb[1] = 7'd40; b_d[4] = 7'd43;  send(6'h02, 6'h00, 6'h10, 1, "R8 first hazard wins");
    base_pkt(); b_sa[2] = 7'd40; b_d[2] = 7'd41;  send(6'h04, 6'h00, 6'h04, 2, "R10 two types");
    base_pkt(); b_v[0] = 0; b_sa[1] = 7'd40;      send(6'h00, 6'h00, 6'h00, 0, "R8 slot0 invalid");
    base_pkt(); b_sb[5] = 7'd44;                  send(6'h20, 6'h00, 6'h00, 5, "R1 last slot");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 latency queue drained", exp_q.size(), 0);

    // R9: mid-run reset clears registered outputs
    base_pkt(); b_sa[3] = 7'd41; apply_pkt(); rst = 1'b1;
    @(negedge clk);
    check(hold_flag == '0 && issue_cnt == '0, "R9 midrun reset", {hold_flag, issue_cnt}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(raw_flag == 6'h08 && issue_cnt == 3'd3, "R9 after reset R1", {raw_flag, issue_cnt}, {6'h08, 3'd3});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule